// File: doc/BRIEF.md
# Snooping Coherence Controller for a Single Shared Line

This block is the central arbiter and responder for a group of caches that share one line of backing storage. Each cache can ask for the line's data, for permission to store into a copy it already holds, or for both at once. The controller accepts one request at a time and queries the snoop side of every other cache. It collects their answers, then replies to the requester with the line data and the coherence state it may adopt. The backing storage is a single register inside the controller.

Only one transaction is in flight anywhere in the system, so a cache never has to answer snoops while its own request holds its line locked. A busy flag tells the caches when a transaction is under way. It rises in the very cycle a request is accepted, so caches that sample it hold back new requests. Requests that arrive together are served in round-robin order. A grant of store permission invalidates every other copy. A data request gets Shared when another cache still holds the line, and Exclusive when none does.

Top module: `snoopCtrl`

## Requirements
- R1: After reset the controller is idle: busy, reqAccept, snpReq and rspValid are all zero. The backing register holds INIT_VALUE, which the first data response returns when no cache holds the line.
- R2: Each cache drives a 2-bit request code at reqKind[2i+1:2i]: 00 no request, 01 data, 10 permission to store, 11 data plus permission. Code 00 is never accepted and leaves busy low.
- R3: In an idle cycle with at least one nonzero code, reqAccept is one-hot for the winner in that same cycle. The search starts at the cache after the last winner. After reset, cache 0 has first priority.
- R4: busy is high from the accept cycle through the response cycle and low in the next cycle unless a new request is accepted then. No request is accepted while a transaction is in flight.
- R5: In the cycle after the accept, snpReq goes high for every cache except the requester. Each bit stays high until that cache raises snpAck, and drops in the following cycle. snpInval is high during the snoop exactly when the request code has bit 1 set.
- R6: rspValid is one-hot for the requester for one cycle. That cycle follows the cycle in which the last outstanding acknowledgement is seen, or follows the accept by two cycles when there is no other cache.
- R7: A data request (01) is answered with rspState Shared (01) if any acknowledging cache reported snpHasCopy, and Exclusive (10) otherwise. The encoding is 00 Invalid, 01 Shared, 10 Exclusive, 11 Modified.
- R8: A request with bit 1 set (10 or 11) is answered with rspState Modified (11).
- R9: rspHasData is high for codes 01 and 11 and low for 10. When it is high, rspData carries the dirty data from the snoop if a snooped cache reported snpDirty, and the backing register otherwise.
- R10: Dirty data returned by a snoop is written into the backing register. A later data response with no dirty snoop returns that value, so every data response carries the newest stored value.
- R11: Caches follow two snoop rules. An invalidating snoop leaves the line Invalid. A non-invalidating snoop turns Modified or Exclusive into Shared. Under these rules no two caches are ever Modified, and no cache is Shared while another is Modified or Exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqKind | input | 2*NUM_CACHES | Per-cache request code, held until accepted |
| reqAccept | output | NUM_CACHES | One-hot acceptance of the winning request |
| busy | output | 1 | A transaction is in flight or being accepted |
| snpReq | output | NUM_CACHES | Snoop query per cache, held until acknowledged |
| snpInval | output | 1 | The current snoop invalidates the snooped copy |
| snpAck | input | NUM_CACHES | Snoop acknowledgement per cache |
| snpHasCopy | input | NUM_CACHES | Snooped cache holds a valid copy (sampled with its ack) |
| snpDirty | input | NUM_CACHES | Snooped cache holds a modified copy (sampled with its ack) |
| snpData | input | NUM_CACHES*DATA_W | Line data from each snooped cache |
| rspValid | output | NUM_CACHES | One-hot response strobe to the requester |
| rspHasData | output | 1 | The response carries line data |
| rspState | output | 2 | Coherence state granted to the requester |
| rspData | output | DATA_W | Line data returned with the response |

## Verification
The bench builds the controller with four caches and 8-bit data. Three snoop targets per transaction and per-cache acknowledgement delays of 0 to 3 cycles make the acknowledgements arrive out of order. The arbiter pointer wraps past the last cache. Each 2-bit request code reaches the controller both from directed sequences and from a long pseudo-random run. The random run also covers upgrades that turn into combined requests after an invalidation, dirty write-backs followed by clean reads from the backing register, and simultaneous requests from all four caches.

// File: rtl/snoopPkg.sv
`timescale 1ns/1ps
package snoopPkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BCAST   = 2'd1,
    ST_COLLECT = 2'd2,
    ST_RESP    = 2'd3
  } ctrlState_e;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } lineState_e;

  localparam logic [1:0] KIND_NONE = 2'b00;
  localparam logic [1:0] KIND_DATA = 2'b01;
  localparam logic [1:0] KIND_PERM = 2'b10;
  localparam logic [1:0] KIND_BOTH = 2'b11;

  // control-to-datapath strobes
  typedef struct packed {
    logic accept;   // latch the winning request
    logic snoop;    // snoop phase: queries out, acks sampled
    logic respond;  // response cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/snoopArbiter.sv
`timescale 1ns/1ps
module snoopArbiter #(
  parameter int NUM_CACHES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CACHES-1:0] reqVec,
  input  logic                  advance,
  output logic [NUM_CACHES-1:0] winOneHot,
  output logic                  anyReq
);
  localparam int IDXW = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1;

  logic [IDXW-1:0] lastIdx;
  logic [IDXW-1:0] winIdx;

  // walk from the farthest candidate to the nearest so the nearest wins
  always_comb begin
    winOneHot = '0;
    winIdx    = lastIdx;
    anyReq    = |reqVec;
    for (int off = NUM_CACHES; off >= 1; off--) begin
      int cand;
      cand = (int'(lastIdx) + off) % NUM_CACHES;
      if (reqVec[cand]) begin
        winOneHot       = '0;
        winOneHot[cand] = 1'b1;
        winIdx          = IDXW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastIdx <= IDXW'(NUM_CACHES - 1);
    end else if (advance) begin
      lastIdx <= winIdx;
    end
  end

endmodule

// File: rtl/snoopCtrlFsm.sv
`timescale 1ns/1ps
module snoopCtrlFsm
  import snoopPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyReq,
  input  logic        snoopDone,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  ctrlState_e state;
  ctrlState_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (anyReq) stateNext = ST_BCAST;
      ST_BCAST,
      ST_COLLECT: stateNext = snoopDone ? ST_RESP : ST_COLLECT;
      ST_RESP:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.accept  = (state == ST_IDLE) && anyReq;
    strobe.snoop   = (state == ST_BCAST) || (state == ST_COLLECT);
    strobe.respond = (state == ST_RESP);
    busy           = (state != ST_IDLE) || strobe.accept;
  end

endmodule

// File: rtl/snoopCtrlPath.sv
`timescale 1ns/1ps
module snoopCtrlPath
  import snoopPkg::*;
#(
  parameter int                NUM_CACHES = 4,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] INIT_VALUE = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic [NUM_CACHES-1:0]        winOneHot,
  input  logic [2*NUM_CACHES-1:0]      reqKind,
  input  logic [NUM_CACHES-1:0]        snpAck,
  input  logic [NUM_CACHES-1:0]        snpHasCopy,
  input  logic [NUM_CACHES-1:0]        snpDirty,
  input  logic [NUM_CACHES*DATA_W-1:0] snpData,
  output logic [NUM_CACHES-1:0]        snpReq,
  output logic                         snpInval,
  output logic                         snoopDone,
  output logic [NUM_CACHES-1:0]        rspValid,
  output logic                         rspHasData,
  output logic [1:0]                   rspState,
  output logic [DATA_W-1:0]            rspData
);
  logic [NUM_CACHES-1:0] ownerVec;
  logic [1:0]            ownerKind;
  logic [NUM_CACHES-1:0] pendVec;
  logic                  copySeen;
  logic [DATA_W-1:0]     memLine;

  logic [1:0]            winKind;
  logic [NUM_CACHES-1:0] ackHit;
  logic                  ackCopy;
  logic                  ackDirty;
  logic [DATA_W-1:0]     ackData;
  lineState_e            grantState;

  always_comb begin
    winKind = KIND_NONE;
    for (int i = 0; i < NUM_CACHES; i++) begin
      winKind = winKind | (reqKind[2*i +: 2] & {2{winOneHot[i]}});
    end
  end

  assign ackHit    = snpAck & pendVec & {NUM_CACHES{strobe.snoop}};
  assign snoopDone = ((pendVec & ~ackHit) == '0);
  assign ackCopy   = |(ackHit & snpHasCopy);
  assign ackDirty  = |(ackHit & snpDirty);

  always_comb begin
    ackData = memLine;
    for (int i = 0; i < NUM_CACHES; i++) begin
      if (ackHit[i] && snpDirty[i]) ackData = snpData[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerVec  <= '0;
      ownerKind <= KIND_NONE;
      pendVec   <= '0;
      copySeen  <= 1'b0;
      memLine   <= INIT_VALUE;
    end else if (strobe.accept) begin
      ownerVec  <= winOneHot;
      ownerKind <= winKind;
      pendVec   <= ~winOneHot;
      copySeen  <= 1'b0;
    end else if (strobe.snoop) begin
      pendVec <= pendVec & ~ackHit;
      if (ackCopy)  copySeen <= 1'b1;
      if (ackDirty) memLine  <= ackData;
    end
  end

  always_comb begin
    if (ownerKind[1])  grantState = LS_MOD;
    else if (copySeen) grantState = LS_SHR;
    else               grantState = LS_EXC;
  end

  assign snpReq     = pendVec & {NUM_CACHES{strobe.snoop}};
  assign snpInval   = strobe.snoop & ownerKind[1];
  assign rspValid   = ownerVec & {NUM_CACHES{strobe.respond}};
  assign rspHasData = strobe.respond & ownerKind[0];
  assign rspState   = strobe.respond ? grantState : LS_INV;
  assign rspData    = rspHasData ? memLine : '0;

endmodule

// File: rtl/snoopCtrl.sv
`timescale 1ns/1ps
module snoopCtrl
  import snoopPkg::*;
#(
  parameter int                NUM_CACHES = 4,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] INIT_VALUE = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [2*NUM_CACHES-1:0]      reqKind,
  output logic [NUM_CACHES-1:0]        reqAccept,
  output logic                         busy,
  output logic [NUM_CACHES-1:0]        snpReq,
  output logic                         snpInval,
  input  logic [NUM_CACHES-1:0]        snpAck,
  input  logic [NUM_CACHES-1:0]        snpHasCopy,
  input  logic [NUM_CACHES-1:0]        snpDirty,
  input  logic [NUM_CACHES*DATA_W-1:0] snpData,
  output logic [NUM_CACHES-1:0]        rspValid,
  output logic                         rspHasData,
  output logic [1:0]                   rspState,
  output logic [DATA_W-1:0]            rspData
);
  logic [NUM_CACHES-1:0] reqLive;
  logic [NUM_CACHES-1:0] winOneHot;
  logic                  anyReq;
  logic                  snoopDone;
  ctrlStrobe_t           strobe;

  for (genvar g = 0; g < NUM_CACHES; g++) begin : g_live
    assign reqLive[g] = |reqKind[2*g +: 2];
  end

  snoopArbiter #(.NUM_CACHES(NUM_CACHES)) u_arb (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqLive),
    .advance   (strobe.accept),
    .winOneHot (winOneHot),
    .anyReq    (anyReq)
  );

  snoopCtrlFsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .anyReq    (anyReq),
    .snoopDone (snoopDone),
    .strobe    (strobe),
    .busy      (busy)
  );

  snoopCtrlPath #(
    .NUM_CACHES (NUM_CACHES),
    .DATA_W     (DATA_W),
    .INIT_VALUE (INIT_VALUE)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .winOneHot  (winOneHot),
    .reqKind    (reqKind),
    .snpAck     (snpAck),
    .snpHasCopy (snpHasCopy),
    .snpDirty   (snpDirty),
    .snpData    (snpData),
    .snpReq     (snpReq),
    .snpInval   (snpInval),
    .snoopDone  (snoopDone),
    .rspValid   (rspValid),
    .rspHasData (rspHasData),
    .rspState   (rspState),
    .rspData    (rspData)
  );

  assign reqAccept = winOneHot & {NUM_CACHES{strobe.accept}};

endmodule

// File: rtl/snoopCtrlChecker.sv
`timescale 1ns/1ps
module snoopCtrlChecker #(
  parameter int NUM_CACHES = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [2*NUM_CACHES-1:0] reqKind,
  input logic [NUM_CACHES-1:0]   reqAccept,
  input logic                    busy,
  input logic [NUM_CACHES-1:0]   snpReq,
  input logic                    snpInval,
  input logic [NUM_CACHES-1:0]   rspValid,
  input logic                    rspHasData,
  input logic [1:0]              rspState
);
  logic                  inFlight;
  logic [NUM_CACHES-1:0] ownerSeen;
  logic [1:0]            kindSeen;
  logic [1:0]            kindAtAccept;
  logic [NUM_CACHES-1:0] liveVec;

  always_comb begin
    kindAtAccept = 2'b00;
    for (int i = 0; i < NUM_CACHES; i++) begin
      liveVec[i]   = |reqKind[2*i +: 2];
      kindAtAccept = kindAtAccept | (reqKind[2*i +: 2] & {2{reqAccept[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight  <= 1'b0;
      ownerSeen <= '0;
      kindSeen  <= 2'b00;
    end else if (|reqAccept) begin
      inFlight  <= 1'b1;
      ownerSeen <= reqAccept;
      kindSeen  <= kindAtAccept;
    end else if (|rspValid) begin
      inFlight  <= 1'b0;
    end
  end

  AST_ACCEPT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqAccept)); // R3
  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (|reqAccept) |-> busy); // R3
  AST_ACCEPT_LIVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccept & ~liveVec) == '0); // R2
  AST_NO_ACCEPT_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> (reqAccept == '0)); // R4
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> busy); // R4
  AST_SNOOP_SKIPS_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (snpReq & ownerSeen) == '0); // R5
  AST_SNOOP_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (|snpReq) |-> inFlight); // R5
  AST_INVAL_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|snpReq) |-> (snpInval == kindSeen[1])); // R5
  AST_RSP_TO_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (|rspValid) |-> (inFlight && rspValid == ownerSeen)); // R6
  AST_RSP_NO_SNOOP: assert property (@(posedge clk) disable iff (!rstN)
    (|rspValid) |-> (snpReq == '0)); // R6
  AST_LOAD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    ((|rspValid) && kindSeen == 2'b01) |-> (rspState == 2'b01 || rspState == 2'b10)); // R7
  AST_STORE_MODIFIED: assert property (@(posedge clk) disable iff (!rstN)
    ((|rspValid) && kindSeen[1]) |-> (rspState == 2'b11)); // R8
  AST_DATA_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (|rspValid) |-> (rspHasData == kindSeen[0])); // R9

endmodule

bind snoopCtrl snoopCtrlChecker #(.NUM_CACHES(NUM_CACHES)) u_snoopChk (.*);

// File: tb/snoopCtrl_bench.sv
`timescale 1ns/1ps
module snoopCtrl_bench;
  localparam int N = 4;
  localparam int W = 8;
  localparam logic [W-1:0] INIT = 8'h5A;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [2*N-1:0] reqKind = '0;
  logic [N-1:0]   reqAccept;
  logic           busy;
  logic [N-1:0]   snpReq;
  logic           snpInval;
  logic [N-1:0]   snpAck = '0;
  logic [N-1:0]   snpHasCopy = '0;
  logic [N-1:0]   snpDirty = '0;
  logic [N*W-1:0] snpData = '0;
  logic [N-1:0]   rspValid;
  logic           rspHasData;
  logic [1:0]     rspState;
  logic [W-1:0]   rspData;

  snoopCtrl #(.NUM_CACHES(N), .DATA_W(W), .INIT_VALUE(INIT)) u_snoopCtrl (.*);

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nErrors = 0;

  // reference model of the controller
  int           mPhase;   // 0 idle, 1 snooping, 2 responding
  int           mOwner, mKind, mLast;
  bit [N-1:0]   mPend;
  bit           mCopy;
  logic [W-1:0] mMem;
  // cache models: state 0 I, 1 S, 2 E, 3 M
  int           cst[N];
  logic [W-1:0] cdata[N];
  int           ckind[N];
  bit           cwaitRsp[N];
  int           cwait[N];
  int           cdelay[N] = '{0, 2, 1, 3};
  int           wantOp[N];  // 0 none, 1 load, 2 store
  logic [W-1:0] newest;
  int unsigned  lfsr = 32'h1234_5678;

  function automatic void check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endfunction

  function automatic bit quiet();
    if (mPhase != 0) return 1'b0;
    for (int i = 0; i < N; i++)
      if (ckind[i] != 0 || cwaitRsp[i] || wantOp[i] != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step();
    logic [N-1:0] ackV, expAcc, expSnp, expRsp;
    logic         expBusy, obsBusy, expHas;
    logic [1:0]   expState;
    int           win, cntM, cntME, cntS;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      reqKind[2*i +: 2]  = 2'(ckind[i]);
      snpHasCopy[i]      = (cst[i] != 0);
      snpDirty[i]        = (cst[i] == 3);
      snpData[i*W +: W]  = cdata[i];
      ackV[i]            = snpReq[i] && (cwait[i] >= cdelay[i]);
    end
    snpAck = ackV;
    #1;
    expAcc = '0; expSnp = '0; expRsp = '0; expBusy = 1'b0; win = -1;
    expState = 2'b00; expHas = 1'b0;
    case (mPhase)
      0: begin
        for (int off = 1; off <= N; off++) begin
          int cand;
          cand = (mLast + off) % N;
          if (win < 0 && ckind[cand] != 0) win = cand;
        end
        if (win >= 0) begin expAcc[win] = 1'b1; expBusy = 1'b1; end
      end
      1: begin expSnp = mPend; expBusy = 1'b1; end
      default: begin
        expRsp[mOwner] = 1'b1; expBusy = 1'b1;
        expState = ((mKind & 2) != 0) ? 2'b11 : (mCopy ? 2'b01 : 2'b10);
        expHas   = ((mKind & 1) != 0);
      end
    endcase
    check(busy === expBusy, "R4 busy", 64'(busy), 64'(expBusy));
    check(reqAccept === expAcc, "R3 accept", 64'(reqAccept), 64'(expAcc));
    check(snpReq === expSnp, "R5 snoop", 64'(snpReq), 64'(expSnp));
    check(rspValid === expRsp, "R6 response", 64'(rspValid), 64'(expRsp));
    if (mPhase == 1)
      check(snpInval === ((mKind & 2) != 0), "R5 inval", 64'(snpInval), 64'((mKind & 2) != 0));
    if (mPhase == 2) begin
      if ((mKind & 2) != 0) check(rspState === expState, "R8 state", 64'(rspState), 64'(expState));
      else                  check(rspState === expState, "R7 state", 64'(rspState), 64'(expState));
      check(rspHasData === expHas, "R9 hasData", 64'(rspHasData), 64'(expHas));
      if (expHas) begin
        check(rspData === mMem, "R9 data", 64'(rspData), 64'(mMem));
        check(rspData === newest, "R10 newest", 64'(rspData), 64'(newest));
      end
    end
    obsBusy = busy;
    // advance model and caches
    case (mPhase)
      0: if (win >= 0) begin
        mOwner = win; mKind = ckind[win]; mLast = win; mCopy = 1'b0;
        mPend = '1; mPend[win] = 1'b0;
        ckind[win] = 0; cwaitRsp[win] = 1'b1; mPhase = 1;
      end
      1: begin
        for (int i = 0; i < N; i++) begin
          if (ackV[i] && mPend[i]) begin
            if (cst[i] != 0) mCopy = 1'b1;
            if (cst[i] == 3) mMem = cdata[i];
            mPend[i] = 1'b0;
            if ((mKind & 2) != 0) begin
              cst[i] = 0;
              if (ckind[i] == 2) ckind[i] = 3;
            end else if (cst[i] >= 2) cst[i] = 1;
            cwait[i] = 0;
          end else if (snpReq[i]) cwait[i]++;
        end
        if (mPend == '0) mPhase = 2;
      end
      default: begin
        cst[mOwner] = int'(expState);
        if (expHas) cdata[mOwner] = mMem;
        if (expState == 2'b11) begin
          newest = newest + 1'b1;
          cdata[mOwner] = newest;
        end
        cwaitRsp[mOwner] = 1'b0;
        mPhase = 0;
      end
    endcase
    cntM = 0; cntME = 0; cntS = 0;
    for (int i = 0; i < N; i++) begin
      if (cst[i] == 3) cntM++;
      if (cst[i] >= 2) cntME++;
      if (cst[i] == 1) cntS++;
    end
    check(cntM <= 1 && cntME <= 1 && !(cntME > 0 && cntS > 0), "R11 states",
          64'(cntME * 16 + cntS), 64'(0));
    // issue new operations for the next cycle
    for (int i = 0; i < N; i++) begin
      if (wantOp[i] != 0 && !cwaitRsp[i] && ckind[i] == 0) begin
        if (wantOp[i] == 1) begin
          if (cst[i] != 0) begin
            check(cdata[i] === newest, "R11 hit data", 64'(cdata[i]), 64'(newest));
            wantOp[i] = 0;
          end else if (!obsBusy) begin
            ckind[i] = 1; wantOp[i] = 0;
          end
        end else begin
          if (cst[i] == 3) begin
            newest = newest + 1'b1; cdata[i] = newest; wantOp[i] = 0;
          end else if (!obsBusy) begin
            ckind[i] = (cst[i] == 0) ? 3 : 2; wantOp[i] = 0;
          end
        end
      end
    end
  endtask

  task automatic runQuiet();
    int guard;
    guard = 0;
    do begin step(); guard++; end while (!quiet() && guard < 2000);
    check(quiet(), "R6 completion", 64'(guard), 64'(0));
  endtask

  initial begin
    mPhase = 0; mOwner = 0; mKind = 0; mLast = N - 1; mPend = '0; mCopy = 1'b0;
    mMem = INIT; newest = INIT;
    for (int i = 0; i < N; i++) begin
      cst[i] = 0; cdata[i] = '0; ckind[i] = 0; cwaitRsp[i] = 1'b0; cwait[i] = 0; wantOp[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(busy === 1'b0, "R1 busy", 64'(busy), 0);
    check(reqAccept === '0, "R1 accept", 64'(reqAccept), 0);
    check(snpReq === '0, "R1 snoop", 64'(snpReq), 0);
    check(rspValid === '0, "R1 response", 64'(rspValid), 0);
    // zero codes only: nothing accepted
    for (int k = 0; k < 4; k++) begin
      step();
      check(busy === 1'b0 && reqAccept === '0, "R2 idle codes", 64'({busy, reqAccept}), 0);
    end
    // first load, no other copy: Exclusive with the initial value
    wantOp[0] = 1; runQuiet();
    check(cst[0] == 2, "R7 exclusive", 64'(cst[0]), 2);
    check(cdata[0] === INIT, "R1 init value", 64'(cdata[0]), 64'(INIT));
    // second load: both Shared
    wantOp[1] = 1; runQuiet();
    check(cst[0] == 1 && cst[1] == 1, "R7 shared", 64'(cst[0] * 4 + cst[1]), 5);
    // combined request from an invalid cache
    wantOp[2] = 2; runQuiet();
    check(cst[2] == 3 && cst[0] == 0 && cst[1] == 0, "R8 modified", 64'(cst[2]), 3);
    // dirty write-back then a clean read from the backing register
    wantOp[2] = 2; runQuiet();
    wantOp[3] = 1; runQuiet();
    check(mMem === newest, "R10 write-back", 64'(mMem), 64'(newest));
    wantOp[0] = 1; runQuiet();
    // upgrade from Shared
    wantOp[0] = 2; runQuiet();
    check(cst[0] == 3, "R8 upgrade", 64'(cst[0]), 3);
    // simultaneous requests
    wantOp[1] = 1; wantOp[2] = 1; wantOp[3] = 2; runQuiet();
    wantOp[0] = 2; wantOp[1] = 2; wantOp[2] = 2; wantOp[3] = 2; runQuiet();
    // pseudo-random traffic
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        if (wantOp[i] == 0) begin
          int r;
          lfsr = lfsr * 32'd1103515245 + 32'd12345;
          r = int'((lfsr >> 16) % 8);
          wantOp[i] = (r == 0) ? 1 : ((r == 1) ? 2 : 0);
        end
      end
      step();
    end
    runQuiet();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #3_000_000;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule